// File: doc/BRIEF.md
# Barrel Shifter with Carry

This block is a purely combinational operand shifter for a 32-bit processor datapath. It takes an operand, a shift kind, an 8-bit shift distance and the current carry flag. It returns the shifted value and the carry the shifter hands to the flag logic. Five shift kinds are offered: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag.

The carry-out follows processor rules rather than plain arithmetic. A zero distance keeps the incoming flag. Logical shifts past the word width clear both outputs. An arithmetic shift saturates to copies of the sign bit. A rotate wraps its distance modulo the width. The caller picks the distance from an immediate field or from the low byte of a register, and feeds the outputs to the ALU and to the flag update logic.

Top module: `barrel_shifter_carry`

## Requirements
- R1: For kinds 0 to 3 a distance of 0 returns the operand unchanged, and carry_out equals carry_in.
- R2: Kind 0 (logical left) with distance n from 1 to 32 returns the operand shifted left by n with zeros filled in, and carry_out is operand bit 32-n. Distance 32 therefore gives result 0 and carry operand bit 0.
- R3: Kind 0 or kind 1 with a distance from 33 to 255 returns 0 with carry_out 0.
- R4: Kind 1 (logical right) with distance n from 1 to 32 returns the operand shifted right by n with zeros filled in, and carry_out is operand bit n-1.
- R5: Kind 2 (arithmetic right) with distance n from 1 to 32 fills vacated bits with operand bit 31, and carry_out is operand bit n-1. With a distance from 33 to 255 every result bit and carry_out equal operand bit 31.
- R6: Kind 3 (rotate right) with a nonzero distance rotates by the distance modulo 32, and carry_out is bit 31 of the rotated result. A nonzero multiple of 32 therefore returns the operand with carry_out equal to operand bit 31.
- R7: Kind 4 (rotate through carry) ignores the distance. The result is carry_in in bit 31 above operand bits 31 to 1, and carry_out is operand bit 0.
- R8: Kinds 5, 6 and 7 return the operand unchanged with carry_out equal to carry_in, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| operand | input | 32 | Value to be shifted |
| amount | input | 8 | Shift distance, unsigned |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry for the flag logic |

## Verification
Every kind from 0 to 7 is tried at the distances 0, 1, 31, 32, 33 and 255, with both carry values and with operands that have the sign bit set and clear. These points separate the pass-through case, the one-bit case, the last in-range distance, the exact-width case where left and right shifts still produce a carry, and the saturated region where logical and arithmetic shifts part ways. Walking-one operands show which source bit a carry comes from. Seeded random kinds, distances and operands then cover the distances in between, and the rotate modulo wrap above 32.

// File: rtl/barrel_shifter_carry.sv
module barrel_shifter_carry #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [2:0]       sh_kind,
  input  logic [W-1:0]     operand,
  input  logic [AMT_W-1:0] amount,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out
);

  localparam int RW = $clog2(W);

  logic [2*W-1:0]    lsl_ext;
  logic [W:0]        lsr_ext;
  logic signed [W:0] asr_ext;
  logic [2*W-1:0]    ror_ext;
  logic [RW-1:0]     rot;
  logic              zero_amt;

  assign zero_amt = (amount == '0);
  assign lsl_ext  = {{W{1'b0}}, operand} << amount;
  assign lsr_ext  = {operand, 1'b0} >> amount;
  assign asr_ext  = $signed({operand, 1'b0}) >>> amount;
  assign rot      = RW'(amount % AMT_W'(W));
  assign ror_ext  = {operand, operand} >> rot;

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    case (sh_kind)
      3'd0: if (!zero_amt) begin
        result    = lsl_ext[W-1:0];
        carry_out = lsl_ext[W];
      end
      3'd1: if (!zero_amt) begin
        result    = lsr_ext[W:1];
        carry_out = lsr_ext[0];
      end
      3'd2: if (!zero_amt) begin
        result    = asr_ext[W:1];
        carry_out = asr_ext[0];
      end
      3'd3: if (!zero_amt) begin
        result    = ror_ext[W-1:0];
        carry_out = ror_ext[W-1];
      end
      3'd4: begin
        result    = {carry_in, operand[W-1:1]};
        carry_out = operand[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (sh_kind < 3'd4 && zero_amt)
      p_zero_pass_r1: assert (result == operand && carry_out == carry_in);
    if (sh_kind < 3'd2 && amount > AMT_W'(W))
      p_wide_clear_r3: assert (result == '0 && !carry_out);
    if (sh_kind == 3'd2 && !zero_amt)
      p_sign_kept_r5: assert (result[W-1] == operand[W-1]);
    if (sh_kind == 3'd3)
      p_bits_kept_r6: assert ($countones(result) == $countones(operand));
    if (sh_kind == 3'd4)
      p_through_carry_r7: assert (result[W-1] == carry_in && carry_out == operand[0]);
    if (sh_kind > 3'd4)
      p_spare_pass_r8: assert (result == operand && carry_out == carry_in);
  end

endmodule

// File: tb/tb_barrel_shifter_carry.sv
module tb_barrel_shifter_carry;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [2:0]  sh_kind;
  logic [31:0] operand;
  logic [7:0]  amount;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shifter_carry dut (
    .sh_kind(sh_kind), .operand(operand), .amount(amount),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] v,
                                        input int n, input logic ci);
    logic [31:0] r;
    logic c;
    r = v;
    c = ci;
    if (k == 3'd4) begin
      for (int i = 0; i < 31; i++) r[i] = v[i+1];
      r[31] = ci;
      c = v[0];
    end else if (k < 3'd4 && n != 0) begin
      for (int i = 0; i < 32; i++) begin
        case (k)
          3'd0: r[i] = (i >= n) ? v[i-n] : 1'b0;
          3'd1: r[i] = (i + n < 32) ? v[i+n] : 1'b0;
          3'd2: r[i] = (i + n < 32) ? v[i+n] : v[31];
          default: r[i] = v[(i + (n % 32)) % 32];
        endcase
      end
      case (k)
        3'd0: c = (n <= 32) ? v[32-n] : 1'b0;
        3'd1: c = (n <= 32) ? v[n-1] : 1'b0;
        3'd2: c = (n <= 32) ? v[n-1] : v[31];
        default: c = r[31];
      endcase
    end
    return {c, r};
  endfunction

  function automatic string tag(input logic [2:0] k, input int n);
    if (k > 3'd4) return "R8";
    if (k == 3'd4) return "R7";
    if (n == 0) return "R1";
    if (k < 3'd2 && n > 32) return "R3";
    if (k == 3'd0) return "R2";
    if (k == 3'd1) return "R4";
    if (k == 3'd2) return "R5";
    return "R6";
  endfunction

  task automatic apply(input logic [2:0] k, input logic [31:0] v,
                       input logic [7:0] n, input logic ci);
    logic [32:0] exp;
    @(posedge clk);
    sh_kind = k; operand = v; amount = n; carry_in = ci;
    exp = model(k, v, int'(n), ci);
    @(negedge clk);
    checks++;
    if ({carry_out, result} !== exp) begin
      errors++;
      $display("FAIL %s kind=%0d op=%h amt=%0d cin=%0b: got c=%0b r=%h, expected c=%0b r=%h",
               tag(k, int'(n)), k, v, n, ci, carry_out, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ops [4];
    int unsigned seed;
    int amts [6];
    ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hA5C3_0F96; ops[3] = 32'h1234_5678;
    amts[0] = 0; amts[1] = 1; amts[2] = 31; amts[3] = 32; amts[4] = 33; amts[5] = 255;
    sh_kind = '0; operand = '0; amount = '0; carry_in = 1'b0;
    seed = 32'd20240917;
    void'($urandom(seed));

    // R1..R8 directed corners: every kind at the boundary distances
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 6; a++)
        for (int o = 0; o < 4; o++)
          for (int ci = 0; ci < 2; ci++)
            apply(3'(k), ops[o], 8'(amts[a]), 1'(ci));

    // R2, R4, R5: walking one shows which bit the carry comes from
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 32; b++)
        for (int n = 1; n <= 32; n += 7)
          apply(3'(k), 32'h1 << b, 8'(n), 1'b0);

    // R6: rotate wrap above the width
    for (int n = 32; n < 256; n += 17)
      apply(3'd3, 32'hF000_000F, 8'(n), 1'b1);

    for (int i = 0; i < 4000; i++)
      apply(3'($urandom), $urandom, 8'($urandom), 1'($urandom));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule